// File: doc/BRIEF.md
# Block-Aligned DMA Request Splitter

This block takes a single DMA transfer, described by a command, a starting byte address, a byte length and an optional no-allocate hint, and turns it into a series of address-bus requests. Each request covers exactly one aligned memory block touched by the byte range. Every request carries the aligned block address, the byte offset of the first useful byte within that block, and the number of bytes it moves. The first request may be partial at its head, the last may be partial at its tail, and all requests between them cover a whole block.

For writes, every request the bus accepts also places a data-phase entry holding that request's byte count into a small queue. The block then asks for the data bus until the queue drains. Completions returned by memory are counted separately from issued requests. A one-cycle done pulse marks the completion that brings the received count up to the number of requests. The block then goes idle and is ready for the next transfer. Two cumulative counters report the total number of requests and bytes issued since reset.

Top module: `dma_block_splitter`

## Requirements
- R1: The command encoding is 2'b01 for read, issued with `areq_write`=0, and 2'b10 for write, issued as a write-invalidate with `areq_write`=1. Codes 2'b00 and 2'b11 are refused: `xfer_err` is high for exactly the one cycle after the launch, no request is issued, and `xfer_ready` stays high.
- R2: A transfer of length zero is refused in the same way as an illegal command.
- R3: The number of requests equals the number of BLK_BYTES-aligned blocks (default 64) that the range [addr, addr+len) touches. The first request addresses the block that contains the start address, and each accepted request moves the address up by one block. No request is issued beyond the count.
- R4: `areq_ofs` holds the start address modulo the block size on the first request, and 0 on every later request.
- R5: In a multi-block transfer, the first request carries BLK_BYTES minus the start offset. The last carries addr+len minus its block address. Every other request carries BLK_BYTES.
- R6: When the whole range lies inside one block, the single request carries exactly the transfer length.
- R7: `areq_no_alloc` is 1 on every request of a read launched with `xfer_no_alloc`=1, and 0 on every write request.
- R8: While `areq_valid` is high and `areq_accept` is low, the request fields are held, no counter advances, and `areq_valid` stays high.
- R9: Each accepted write request queues an entry holding its byte count. `dbus_req` is high while the queue is non-empty, and `dbus_size` shows the oldest entry. Each `dbus_grant` removes one entry. When DQ_DEPTH entries (default 4) are pending, `areq_valid` is withheld. Reads never raise `dbus_req`.
- R10: `xfer_done` pulses for one cycle, one cycle after the completion that makes the received count equal the request count. It does not pulse earlier, and `xfer_ready` is high again in that same cycle.
- R11: `xfer_ready` is low from the cycle after a transfer launches until its done pulse. A `xfer_valid` presented while busy has no effect.
- R12: `stat_pkts` and `stat_bytes` increase by one and by the request's byte count for every accepted request, accumulate across transfers, and are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | Launch a transfer (taken only when ready) |
| xfer_ready | output | 1 | Block is idle and can take a transfer |
| xfer_cmd | input | 2 | 01 read, 10 write, others illegal |
| xfer_addr | input | ADDR_W | First byte address |
| xfer_len | input | LEN_W | Byte length |
| xfer_no_alloc | input | 1 | Ask for no allocation on reads |
| xfer_err | output | 1 | One-cycle pulse on a refused launch |
| areq_valid | output | 1 | Address-bus request |
| areq_accept | input | 1 | Bus takes the current request |
| areq_addr | output | ADDR_W | Aligned block address |
| areq_ofs | output | log2(BLK_BYTES) | Byte offset inside the block |
| areq_size | output | log2(BLK_BYTES)+1 | Byte count of the request |
| areq_write | output | 1 | 1 = write-invalidate, 0 = read |
| areq_no_alloc | output | 1 | No-allocate hint |
| dbus_req | output | 1 | Data-bus request |
| dbus_grant | input | 1 | Data-bus grant, removes one entry |
| dbus_size | output | log2(BLK_BYTES)+1 | Byte count of the oldest data entry |
| mem_cmpl | input | 1 | One memory completion |
| xfer_done | output | 1 | One-cycle pulse when all completions are in |
| stat_pkts | output | STAT_W | Total requests accepted since reset |
| stat_bytes | output | STAT_W | Total bytes of accepted requests since reset |

## Verification
The embedded properties assume that the bus environment behaves. `dbus_grant` arrives only while `dbus_req` is high. `mem_cmpl` arrives only for a request that has already been accepted and is not yet completed. Address plus length does not run past the top of the address space. The directed bench grants the data bus only after it has seen `dbus_req`, and it returns completions one at a time only after every request of the transfer has been accepted. Its addresses stay well below the address limit. The legality of commands and lengths is not assumed: the bench drives illegal values deliberately, both when the block is idle and when it is busy.

// File: rtl/dsplit_pkg.sv
`timescale 1ns/1ps
package dsplit_pkg;
   typedef enum logic [1:0] {
      CMD_NONE  = 2'b00,
      CMD_READ  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_RSVD  = 2'b11
   } dsplit_cmd_e;

   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } dsplit_phase_e;
endpackage

// File: rtl/dsplit_geom.sv
`timescale 1ns/1ps
// Launch-time geometry: end pointer, first block and number of blocks touched.
module dsplit_geom #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int BLK_BYTES = 64,
   parameter int CNT_W     = 12
) (
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [LEN_W-1:0]  len,
   output logic [ADDR_W:0]   end_addr,
   output logic [ADDR_W-1:0] first_blk,
   output logic [CNT_W-1:0]  pkt_count
);
   localparam int WIDE  = ADDR_W + 1;
   localparam int OFS_W = $clog2(BLK_BYTES);
   localparam logic [WIDE-1:0]   WMASK = WIDE'(BLK_BYTES - 1);
   localparam logic [ADDR_W-1:0] AMASK = ADDR_W'(BLK_BYTES - 1);

   generate
      if ((BLK_BYTES & (BLK_BYTES - 1)) != 0 || BLK_BYTES < 2)
         $error("dsplit_geom: BLK_BYTES must be a power of two of at least 2");
      if (OFS_W + CNT_W > WIDE)
         $error("dsplit_geom: CNT_W too wide for the address span");
   endgenerate

   logic [WIDE-1:0] s_w, e_w, sb_w, eb_w, span_w;

   always_comb begin
      s_w       = {1'b0, start_addr};
      e_w       = s_w + WIDE'(len);
      sb_w      = s_w & ~WMASK;
      eb_w      = (e_w + WMASK) & ~WMASK;
      span_w    = eb_w - sb_w;
      pkt_count = CNT_W'(span_w >> OFS_W);
      end_addr  = e_w;
      first_blk = start_addr & ~AMASK;
   end
endmodule

// File: rtl/dsplit_slice.sv
`timescale 1ns/1ps
// Per-request offset and byte count: head, middle, tail or single-block.
module dsplit_slice #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int BLK_BYTES = 64,
   localparam int OFS_W    = $clog2(BLK_BYTES),
   localparam int SZ_W     = OFS_W + 1
) (
   input  logic [OFS_W-1:0]  start_ofs,
   input  logic [LEN_W-1:0]  len,
   input  logic [ADDR_W:0]   end_addr,
   input  logic [ADDR_W-1:0] cur_blk,
   input  logic              is_first,
   input  logic              is_last,
   input  logic              is_single,
   output logic [OFS_W-1:0]  req_ofs,
   output logic [SZ_W-1:0]   req_size
);
   generate
      if (LEN_W < SZ_W)
         $error("dsplit_slice: LEN_W must cover one block");
   endgenerate

   logic [ADDR_W:0] tail_w;
   logic [SZ_W-1:0] head_sz, tail_sz, one_sz;

   always_comb begin
      tail_w  = end_addr - {1'b0, cur_blk};
      tail_sz = SZ_W'(tail_w);
      head_sz = SZ_W'(BLK_BYTES) - SZ_W'(start_ofs);
      one_sz  = SZ_W'(len);
      req_ofs = is_first ? start_ofs : '0;
      if (is_single)
         req_size = one_sz;
      else if (is_first)
         req_size = head_sz;
      else if (is_last)
         req_size = tail_sz;
      else
         req_size = SZ_W'(BLK_BYTES);
   end
endmodule

// File: rtl/dsplit_dq.sv
`timescale 1ns/1ps
// Data-phase queue of pending write byte counts.
module dsplit_dq #(
   parameter int DEPTH = 4,
   parameter int W     = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   generate
      if (DEPTH < 1)
         $error("dsplit_dq: DEPTH must be at least 1");

      if (DEPTH == 1) begin : g_single
         logic         vld_q;
         logic [W-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '0;
            end else begin
               if (push) begin
                  vld_q <= 1'b1;
                  dat_q <= din;
               end else if (pop) begin
                  vld_q <= 1'b0;
               end
            end
         end
         assign dout  = dat_q;
         assign empty = !vld_q;
         assign full  = vld_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CW    = $clog2(DEPTH + 1);
         logic [W-1:0]     mem [DEPTH];
         logic [PTR_W-1:0] wp_q, rp_q;
         logic [CW-1:0]    cnt_q;

         always_ff @(posedge clk) begin
            if (push) mem[wp_q] <= din;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wp_q  <= '0;
               rp_q  <= '0;
               cnt_q <= '0;
            end else begin
               if (push)
                  wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
               if (pop)
                  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
               if (push && !pop)
                  cnt_q <= cnt_q + 1'b1;
               else if (pop && !push)
                  cnt_q <= cnt_q - 1'b1;
            end
         end
         assign dout  = mem[rp_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CW'(DEPTH));
      end
   endgenerate

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/dma_block_splitter.sv
`timescale 1ns/1ps
module dma_block_splitter
   import dsplit_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 16,
   parameter int BLK_BYTES = 64,
   parameter int DQ_DEPTH  = 4,
   parameter int STAT_W    = 32,
   localparam int OFS_W    = $clog2(BLK_BYTES),
   localparam int SZ_W     = OFS_W + 1,
   localparam int CNT_W    = LEN_W - OFS_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              xfer_valid,
   output logic              xfer_ready,
   input  logic [1:0]        xfer_cmd,
   input  logic [ADDR_W-1:0] xfer_addr,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              xfer_no_alloc,
   output logic              xfer_err,
   output logic              areq_valid,
   input  logic              areq_accept,
   output logic [ADDR_W-1:0] areq_addr,
   output logic [OFS_W-1:0]  areq_ofs,
   output logic [SZ_W-1:0]   areq_size,
   output logic              areq_write,
   output logic              areq_no_alloc,
   output logic              dbus_req,
   input  logic              dbus_grant,
   output logic [SZ_W-1:0]   dbus_size,
   input  logic              mem_cmpl,
   output logic              xfer_done,
   output logic [STAT_W-1:0] stat_pkts,
   output logic [STAT_W-1:0] stat_bytes
);
   generate
      if (ADDR_W < 8 || LEN_W <= OFS_W)
         $error("dma_block_splitter: address or length width too small");
      if (DQ_DEPTH < 1)
         $error("dma_block_splitter: DQ_DEPTH must be at least 1");
   endgenerate

   dsplit_phase_e     phase_q;
   logic              wr_q, na_q, err_q, done_q;
   logic [OFS_W-1:0]  sofs_q;
   logic [LEN_W-1:0]  len_q;
   logic [ADDR_W:0]   end_q;
   logic [ADDR_W-1:0] cur_q;
   logic [CNT_W-1:0]  npk_q, sent_q, recv_q;
   logic [STAT_W-1:0] stp_q, stb_q;

   logic [ADDR_W:0]   g_end;
   logic [ADDR_W-1:0] g_first;
   logic [CNT_W-1:0]  g_cnt;
   logic              busy, launch, is_rd, is_wr, bad, more, fire, last_cmpl;
   logic              dq_empty, dq_full;

   // ---------------- launch decode ----------------
   assign busy   = (phase_q == PH_RUN);
   assign launch = xfer_valid && !busy;
   assign is_rd  = (xfer_cmd == CMD_READ);
   assign is_wr  = (xfer_cmd == CMD_WRITE);
   assign bad    = !(is_rd || is_wr) || (xfer_len == '0);

   dsplit_geom #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES), .CNT_W(CNT_W)
   ) u_geom (
      .start_addr(xfer_addr),
      .len       (xfer_len),
      .end_addr  (g_end),
      .first_blk (g_first),
      .pkt_count (g_cnt)
   );

   // ---------------- request slicing ----------------
   dsplit_slice #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)
   ) u_slice (
      .start_ofs(sofs_q),
      .len      (len_q),
      .end_addr (end_q),
      .cur_blk  (cur_q),
      .is_first (sent_q == '0),
      .is_last  (sent_q == npk_q - 1'b1),
      .is_single(npk_q == CNT_W'(1)),
      .req_ofs  (areq_ofs),
      .req_size (areq_size)
   );

   assign more          = busy && (sent_q != npk_q);
   assign areq_valid    = more && !(wr_q && dq_full);
   assign fire          = areq_valid && areq_accept;
   assign areq_addr     = cur_q;
   assign areq_write    = wr_q;
   assign areq_no_alloc = na_q;

   // ---------------- write data-phase queue ----------------
   dsplit_dq #(.DEPTH(DQ_DEPTH), .W(SZ_W)) u_dq (
      .clk  (clk),
      .rst_n(rst_n),
      .push (fire && wr_q),
      .din  (areq_size),
      .pop  (dbus_grant),
      .dout (dbus_size),
      .empty(dq_empty),
      .full (dq_full)
   );
   assign dbus_req = !dq_empty;

   // ---------------- sequencing and counters ----------------
   assign last_cmpl = busy && mem_cmpl && ((recv_q + 1'b1) == npk_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         na_q    <= 1'b0;
         err_q   <= 1'b0;
         done_q  <= 1'b0;
         sofs_q  <= '0;
         len_q   <= '0;
         end_q   <= '0;
         cur_q   <= '0;
         npk_q   <= '0;
         sent_q  <= '0;
         recv_q  <= '0;
         stp_q   <= '0;
         stb_q   <= '0;
      end else begin
         err_q  <= launch && bad;
         done_q <= last_cmpl;
         if (fire) begin
            stp_q <= stp_q + 1'b1;
            stb_q <= stb_q + STAT_W'(areq_size);
         end
         if (launch && !bad) begin
            phase_q <= PH_RUN;
            wr_q    <= is_wr;
            na_q    <= xfer_no_alloc && is_rd;
            sofs_q  <= xfer_addr[OFS_W-1:0];
            len_q   <= xfer_len;
            end_q   <= g_end;
            cur_q   <= g_first;
            npk_q   <= g_cnt;
            sent_q  <= '0;
            recv_q  <= '0;
         end else begin
            if (fire) begin
               sent_q <= sent_q + 1'b1;
               cur_q  <= cur_q + ADDR_W'(BLK_BYTES);
            end
            if (busy && mem_cmpl)
               recv_q <= recv_q + 1'b1;
            if (last_cmpl)
               phase_q <= PH_IDLE;
         end
      end
   end

   assign xfer_ready = !busy;
   assign xfer_err   = err_q;
   assign xfer_done  = done_q;
   assign stat_pkts  = stp_q;
   assign stat_bytes = stb_q;

   // ---------------- properties ----------------
   p_hold_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (areq_valid && !areq_accept) |=>
         (areq_valid && $stable(areq_addr) && $stable(areq_size) && $stable(areq_ofs)));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (areq_valid && areq_accept) |=>
         (!areq_valid || areq_addr == $past(areq_addr) + ADDR_W'(BLK_BYTES)));

   p_size_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      areq_valid |-> (areq_size != '0 &&
                      ({1'b0, areq_ofs} + areq_size) <= SZ_W'(BLK_BYTES)));

   p_no_alloc_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (areq_valid && areq_write) |-> !areq_no_alloc);

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> !xfer_done);

   p_cmpl_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cmpl |-> (busy && recv_q < sent_q));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ready |-> !areq_valid);

   p_err_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_err |-> xfer_ready);
endmodule

// File: tb/test_dma_block_splitter.sv
`timescale 1ns/1ps
module test_dma_block_splitter;
   localparam real CLK_NS = 4.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_valid = 1'b0;
   logic        xfer_ready;
   logic [1:0]  xfer_cmd = 2'b00;
   logic [31:0] xfer_addr = '0;
   logic [15:0] xfer_len = '0;
   logic        xfer_no_alloc = 1'b0;
   logic        xfer_err;
   logic        areq_valid;
   logic        areq_accept = 1'b0;
   logic [31:0] areq_addr;
   logic [5:0]  areq_ofs;
   logic [6:0]  areq_size;
   logic        areq_write;
   logic        areq_no_alloc;
   logic        dbus_req;
   logic        dbus_grant = 1'b0;
   logic [6:0]  dbus_size;
   logic        mem_cmpl = 1'b0;
   logic        xfer_done;
   logic [31:0] stat_pkts;
   logic [31:0] stat_bytes;

   int n_chk = 0;
   int n_err = 0;
   longint exp_pkts = 0;
   longint exp_bytes = 0;
   bit finished = 0;

   always #(CLK_NS / 2.0) clk = ~clk;

   dma_block_splitter i_dma_block_splitter (
      .clk(clk), .rst_n(rst_n),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_cmd(xfer_cmd),
      .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_no_alloc(xfer_no_alloc),
      .xfer_err(xfer_err),
      .areq_valid(areq_valid), .areq_accept(areq_accept), .areq_addr(areq_addr),
      .areq_ofs(areq_ofs), .areq_size(areq_size), .areq_write(areq_write),
      .areq_no_alloc(areq_no_alloc),
      .dbus_req(dbus_req), .dbus_grant(dbus_grant), .dbus_size(dbus_size),
      .mem_cmpl(mem_cmpl), .xfer_done(xfer_done),
      .stat_pkts(stat_pkts), .stat_bytes(stat_bytes)
   );

   task automatic check_eq(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic check_stats(input string tag);
      check_eq({tag, " R12 stat_pkts"}, stat_pkts, exp_pkts);
      check_eq({tag, " R12 stat_bytes"}, stat_bytes, exp_bytes);
   endtask

   task automatic launch(input logic [1:0] cmd, input logic [31:0] addr,
                         input int len, input bit na);
      @(negedge clk);
      xfer_valid = 1'b1; xfer_cmd = cmd; xfer_addr = addr;
      xfer_len = 16'(len); xfer_no_alloc = na;
      @(negedge clk);
      xfer_valid = 1'b0;
   endtask

   // Returns completions one per cycle; checks the done pulse timing (R10).
   task automatic complete_all(input int n);
      for (int i = 0; i < n; i++) begin
         mem_cmpl = 1'b1;
         check_eq("R10 no early done", xfer_done, 0);
         @(negedge clk);
         mem_cmpl = 1'b0;
         if (i < n - 1) check_eq("R10 no done before last", xfer_done, 0);
      end
      check_eq("R10 done pulse", xfer_done, 1);
      check_eq("R10 ready with done", xfer_ready, 1);
      @(negedge clk);
      check_eq("R10 done one cycle", xfer_done, 0);
   endtask

   task automatic run_xfer(input logic [1:0] cmd, input logic [31:0] addr,
                           input int len, input bit na, input bit refuse);
      logic [32:0] sb, en, eb;
      logic [31:0] ba;
      int n, off, sz;
      bit wr;
      string sztag;
      wr = (cmd == 2'b10);
      sb = {1'b0, addr} & ~33'h3F;
      en = {1'b0, addr} + 33'(len);
      eb = (en + 33'h3F) & ~33'h3F;
      n  = int'((eb - sb) >> 6);
      launch(cmd, addr, len, na);
      check_eq("R11 not ready while busy", xfer_ready, 0);
      for (int i = 0; i < n; i++) begin
         ba  = sb[31:0] + 32'(64 * i);
         off = (i == 0) ? int'(addr[5:0]) : 0;
         if (n == 1)          sz = len;
         else if (i == 0)     sz = 64 - int'(addr[5:0]);
         else if (i == n - 1) sz = int'(en - {1'b0, ba});
         else                 sz = 64;
         sztag = (n == 1) ? "R6 single size" : "R5 size";
         if (refuse) begin
            @(negedge clk);
            check_eq("R8 valid held", areq_valid, 1);
            check_eq("R8 addr held", areq_addr, ba);
            check_eq("R8 size held", areq_size, sz);
            check_eq("R8 no advance", stat_pkts, exp_pkts);
         end
         check_eq("R3 request valid", areq_valid, 1);
         check_eq("R3 block addr", areq_addr, ba);
         check_eq("R4 offset", areq_ofs, off);
         check_eq(sztag, areq_size, sz);
         check_eq("R1 write flag", areq_write, wr);
         check_eq("R7 no-alloc flag", areq_no_alloc, na && !wr);
         areq_accept = 1'b1;
         @(negedge clk);
         areq_accept = 1'b0;
         exp_pkts++;
         exp_bytes += sz;
         check_stats("per request");
         if (wr) begin
            check_eq("R9 data request", dbus_req, 1);
            check_eq("R9 data size", dbus_size, sz);
            dbus_grant = 1'b1;
            @(negedge clk);
            dbus_grant = 1'b0;
            check_eq("R9 queue drained", dbus_req, 0);
         end else begin
            check_eq("R9 read has no data phase", dbus_req, 0);
         end
      end
      check_eq("R3 no extra request", areq_valid, 0);
      complete_all(n);
   endtask

   task automatic t_reset;
      check_eq("R11 ready after reset", xfer_ready, 1);
      check_eq("R3 no request after reset", areq_valid, 0);
      check_eq("R9 no data request after reset", dbus_req, 0);
      check_eq("R10 no done after reset", xfer_done, 0);
      check_eq("R1 no error after reset", xfer_err, 0);
      check_stats("reset");
   endtask

   task automatic t_reject(input logic [1:0] cmd, input int len, input string tag);
      launch(cmd, 32'h0000_5000, len, 1'b0);
      check_eq({tag, " error pulse"}, xfer_err, 1);
      check_eq({tag, " stays ready"}, xfer_ready, 1);
      check_eq({tag, " no request"}, areq_valid, 0);
      @(negedge clk);
      check_eq({tag, " error one cycle"}, xfer_err, 0);
      check_eq({tag, " still no request"}, areq_valid, 0);
      check_stats(tag);
   endtask

   task automatic t_busy_ignore;
      launch(2'b01, 32'h0000_0200, 64, 1'b0);
      xfer_valid = 1'b1; xfer_cmd = 2'b10; xfer_addr = 32'h0000_3000; xfer_len = 16'd10;
      @(negedge clk);
      xfer_valid = 1'b0;
      check_eq("R11 busy launch ignored: no error", xfer_err, 0);
      check_eq("R11 busy launch ignored: addr", areq_addr, 32'h200);
      check_eq("R11 busy launch ignored: size", areq_size, 64);
      check_eq("R11 busy launch ignored: read", areq_write, 0);
      areq_accept = 1'b1;
      @(negedge clk);
      areq_accept = 1'b0;
      exp_pkts++; exp_bytes += 64;
      check_eq("R11 only one request", areq_valid, 0);
      check_eq("R11 no data phase", dbus_req, 0);
      complete_all(1);
      check_stats("busy ignore");
   endtask

   task automatic t_backpressure;
      launch(2'b10, 32'h0000_4000, 384, 1'b0);
      for (int i = 0; i < 4; i++) begin
         check_eq("R9 fill addr", areq_addr, 32'h4000 + 32'(64 * i));
         areq_accept = 1'b1;
         @(negedge clk);
      end
      areq_accept = 1'b0;
      check_eq("R9 withheld when queue full", areq_valid, 0);
      check_eq("R9 data request pending", dbus_req, 1);
      check_eq("R9 oldest size", dbus_size, 64);
      dbus_grant = 1'b1;
      @(negedge clk);
      dbus_grant = 1'b0;
      check_eq("R9 resumes after pop", areq_valid, 1);
      check_eq("R9 resume addr", areq_addr, 32'h4100);
      areq_accept = 1'b1;
      @(negedge clk);
      areq_accept = 1'b0;
      check_eq("R9 withheld again", areq_valid, 0);
      dbus_grant = 1'b1;
      @(negedge clk);
      dbus_grant = 1'b0;
      check_eq("R9 last request addr", areq_addr, 32'h4140);
      areq_accept = 1'b1;
      @(negedge clk);
      areq_accept = 1'b0;
      check_eq("R3 all six issued", areq_valid, 0);
      for (int i = 0; i < 4; i++) begin
         check_eq("R9 drain request", dbus_req, 1);
         check_eq("R9 drain size", dbus_size, 64);
         dbus_grant = 1'b1;
         @(negedge clk);
         dbus_grant = 1'b0;
      end
      check_eq("R9 queue empty", dbus_req, 0);
      exp_pkts += 6; exp_bytes += 384;
      check_stats("backpressure");
      complete_all(6);
   endtask

   initial begin
      #(CLK_NS * 100000.0);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      run_xfer(2'b01, 32'h0000_1010, 200, 1'b0, 1'b0); // head/middle/tail read
      run_xfer(2'b10, 32'h0000_2000, 256, 1'b0, 1'b1); // aligned write with refusals
      run_xfer(2'b01, 32'h0000_030A, 20, 1'b0, 1'b0);  // R6 inside one block
      run_xfer(2'b10, 32'h0000_0430, 16, 1'b0, 1'b0);  // R6 ends on boundary
      run_xfer(2'b01, 32'h0000_07F0, 32, 1'b1, 1'b1);  // R7 read no-alloc, two halves
      run_xfer(2'b10, 32'h0000_0905, 70, 1'b1, 1'b0);  // R7 write ignores hint
      t_reject(2'b00, 8, "R1 cmd 00");
      t_reject(2'b11, 8, "R1 cmd 11");
      t_reject(2'b01, 0, "R2 zero length");
      t_busy_ignore();
      t_backpressure();
      check_stats("final");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule